// File: doc/BRIEF.md
# Big-Number Accelerator Register Front End

This block sits between a host bus and a big-number arithmetic engine. The host reaches everything through one flat 12-bit word address. The upper nibble picks a bank and the low byte picks a word inside that bank. Bank 0 holds the control and status registers. Banks 1 to 4 are four separate 256-word operand memories, 32 bits per word. The engine itself is outside this block. It receives a one-cycle start pulse, the three operand lengths, and a private read port into every memory. It returns a completion pulse and writes its answer into the result memory through a port of its own.

The host loads the modulus, exponent and message words and sets the word counts. It then writes the start bit and polls the status register until it reads 1. Finally it fetches the answer from the result bank. Every access returns its read data and its error flag on the cycle after it is presented.

Top module: `bignum_regif`

## Requirements
- R1: The bank is taken from `addr_i[11:8]`: 0 selects general registers, 1 the modulus memory, 2 the exponent memory, 3 the message memory and 4 the result memory. The offset is taken from `addr_i[7:0]`. Each of the three operand memories holds 256 independent 32-bit words, and a host write followed by a host read of the same bank and offset returns the written word.
- R2: `rdata_o` and `err_o` are registered and reflect the access presented at the previous rising edge. `rdata_o` is zero after an idle cycle, a write or an erroneous access. `err_o` is low after an idle cycle.
- R3: General offsets 0x00, 0x01 and 0x02 read the constants 0x626E_7267, 0x6D65_7870 and 0x0001_0000.
- R4: A write to general offset 0x08 with bit 0 set raises `start_o` for exactly the following cycle. With bit 0 clear, no pulse is produced. Offset 0x08 always reads 0.
- R5: General offset 0x09 reads 1 (ready) or 0 (busy). It reads 1 after reset. It drops in the same cycle `start_o` is high, and returns to 1 in the cycle after `done_i`. When start and `done_i` coincide, start wins.
- R6: General offsets 0x20, 0x21 and 0x22 hold the modulus, message and exponent word counts. Each keeps the low 9 bits of the written word, reads back zero-extended, drives `mod_len_o`, `msg_len_o` and `exp_len_o` respectively, and resets to 0.
- R7: An access to bank 5 to 15, or to a general offset other than 0x00, 0x01, 0x02, 0x08, 0x09, 0x20, 0x21 or 0x22, raises `err_o` for one cycle with `rdata_o` zero. Such a write changes no state.
- R8: The result memory (bank 4) is written only through `res_we_i`, `res_waddr_i` and `res_wdata_i`. A host write to bank 4 raises `err_o` and leaves the memory unchanged, and host reads of bank 4 return what the engine wrote.
- R9: `eng_mod_o`, `eng_exp_o`, `eng_msg_o` and `eng_res_o` return, one cycle later, the word at `eng_raddr_i` in the modulus, exponent, message and result memory.
- R10: Host writes to general offsets 0x00, 0x01, 0x02 and 0x09 are ignored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Host access strobe |
| we_i | input | 1 | Host write when high, read when low |
| addr_i | input | 12 | Bank nibble and word offset |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Registered host read data |
| err_o | output | 1 | Registered access error |
| start_o | output | 1 | One-cycle start pulse to the engine |
| done_i | input | 1 | Engine completion pulse |
| mod_len_o | output | 9 | Modulus length in words |
| msg_len_o | output | 9 | Message length in words |
| exp_len_o | output | 9 | Exponent length in words |
| eng_raddr_i | input | 8 | Engine read offset for all memories |
| eng_mod_o | output | 32 | Engine read data, modulus memory |
| eng_exp_o | output | 32 | Engine read data, exponent memory |
| eng_msg_o | output | 32 | Engine read data, message memory |
| eng_res_o | output | 32 | Engine read data, result memory |
| res_we_i | input | 1 | Engine write strobe into result memory |
| res_waddr_i | input | 8 | Engine write offset into result memory |
| res_wdata_i | input | 32 | Engine write data into result memory |

## Verification
The bound assertions check the following on every cycle:
- the start pulse lasts one cycle and only follows a control write with bit 0 set;
- ready is low whenever the pulse is high and only rises after a completion;
- bad banks and host writes to the result bank always raise the error flag;
- an error or an idle cycle never returns data.

The stored contents can only be shown by the bench's scenarios. These cover:
- full-depth write and read sweeps over every memory through both host and engine ports;
- a sweep of all 256 general offsets for the error map;
- the length truncation;
- the ignored writes;
- the start and completion collision.

// File: rtl/bnregif_pkg.sv
`timescale 1ns/1ps
package bnregif_pkg;
  localparam int NMEM    = 4;
  localparam int RES_IDX = 3;

  typedef enum logic [3:0] {
    BANK_GEN = 4'd0,
    BANK_MOD = 4'd1,
    BANK_EXP = 4'd2,
    BANK_MSG = 4'd3,
    BANK_RES = 4'd4
  } bank_e;

  localparam logic [7:0] OFF_ID0  = 8'h00;
  localparam logic [7:0] OFF_ID1  = 8'h01;
  localparam logic [7:0] OFF_VER  = 8'h02;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h09;
  localparam logic [7:0] OFF_LMOD = 8'h20;
  localparam logic [7:0] OFF_LMSG = 8'h21;
  localparam logic [7:0] OFF_LEXP = 8'h22;

  typedef enum logic [1:0] {SRC_NONE, SRC_GEN, SRC_MEM} rsrc_e;
endpackage

// File: rtl/bnregif_decode.sv
`timescale 1ns/1ps
module bnregif_decode
  import bnregif_pkg::*;
#(
  parameter int OW = 8
) (
  input  logic                cs_i,
  input  logic                we_i,
  input  logic [3:0]          prefix_i,
  input  logic [OW-1:0]       off_i,
  output logic                gen_acc_o,
  output logic [NMEM-1:0]     mem_hit_o,
  output logic                bad_o
);
  logic is_gen, off_ok;

  always_comb begin
    is_gen = (prefix_i == BANK_GEN);
    off_ok = (off_i == OW'(OFF_ID0))  || (off_i == OW'(OFF_ID1))  ||
             (off_i == OW'(OFF_VER))  || (off_i == OW'(OFF_CTRL)) ||
             (off_i == OW'(OFF_STAT)) || (off_i == OW'(OFF_LMOD)) ||
             (off_i == OW'(OFF_LMSG)) || (off_i == OW'(OFF_LEXP));
    for (int i = 0; i < NMEM; i++)
      mem_hit_o[i] = cs_i && (prefix_i == 4'(i + 1));
    gen_acc_o = cs_i && is_gen && off_ok;
    bad_o     = cs_i && ((prefix_i > BANK_RES) ||
                         (is_gen && !off_ok) ||
                         (prefix_i == BANK_RES && we_i));
  end
endmodule

// File: rtl/bnregif_gen.sv
`timescale 1ns/1ps
module bnregif_gen
  import bnregif_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          OW      = 8,
  parameter int          LEN_W   = 9,
  parameter logic [31:0] NAME0   = 32'h626E_7267,
  parameter logic [31:0] NAME1   = 32'h6D65_7870,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [OW-1:0]    off_i,
  input  logic [LEN_W-1:0] wdata_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             ready_o,
  output logic [LEN_W-1:0] mod_len_o,
  output logic [LEN_W-1:0] msg_len_o,
  output logic [LEN_W-1:0] exp_len_o,
  output logic [DW-1:0]    rdata_o
);
  logic          wr, go;
  logic [DW-1:0] rd_mux;

  assign wr = acc_i && we_i;
  assign go = wr && (off_i == OW'(OFF_CTRL)) && wdata_i[0];

  always_comb begin
    case (off_i)
      OW'(OFF_ID0):  rd_mux = DW'(NAME0);
      OW'(OFF_ID1):  rd_mux = DW'(NAME1);
      OW'(OFF_VER):  rd_mux = DW'(VERSION);
      OW'(OFF_STAT): rd_mux = DW'(ready_o);
      OW'(OFF_LMOD): rd_mux = DW'(mod_len_o);
      OW'(OFF_LMSG): rd_mux = DW'(msg_len_o);
      OW'(OFF_LEXP): rd_mux = DW'(exp_len_o);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o   <= 1'b0;
      ready_o   <= 1'b1;
      mod_len_o <= '0;
      msg_len_o <= '0;
      exp_len_o <= '0;
      rdata_o   <= '0;
    end else begin
      start_o <= go;
      if (go)          ready_o <= 1'b0;   // start beats a coincident done
      else if (done_i) ready_o <= 1'b1;
      if (wr && off_i == OW'(OFF_LMOD)) mod_len_o <= wdata_i;
      if (wr && off_i == OW'(OFF_LMSG)) msg_len_o <= wdata_i;
      if (wr && off_i == OW'(OFF_LEXP)) exp_len_o <= wdata_i;
      rdata_o <= (acc_i && !we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/bnregif_mem.sv
`timescale 1ns/1ps
module bnregif_mem #(
  parameter int DW = 32,
  parameter int OW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [OW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [OW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [OW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int DEPTH = 1 << OW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    ra_data_o <= mem[ra_addr_i];
    rb_data_o <= mem[rb_addr_i];
  end
endmodule

// File: rtl/bignum_regif.sv
`timescale 1ns/1ps
module bignum_regif
  import bnregif_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 8,
  localparam int AW    = OW + 4,
  localparam int LEN_W = OW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             err_o,
  output logic             start_o,
  input  logic             done_i,
  output logic [LEN_W-1:0] mod_len_o,
  output logic [LEN_W-1:0] msg_len_o,
  output logic [LEN_W-1:0] exp_len_o,
  input  logic [OW-1:0]    eng_raddr_i,
  output logic [DW-1:0]    eng_mod_o,
  output logic [DW-1:0]    eng_exp_o,
  output logic [DW-1:0]    eng_msg_o,
  output logic [DW-1:0]    eng_res_o,
  input  logic             res_we_i,
  input  logic [OW-1:0]    res_waddr_i,
  input  logic [DW-1:0]    res_wdata_i
);
  logic [3:0]      prefix;
  logic [OW-1:0]   off;
  logic            gen_acc, bad, ready_w;
  logic [NMEM-1:0] mem_hit;
  logic [DW-1:0]   gen_rdata;
  logic [DW-1:0]   host_rd [NMEM];
  logic [DW-1:0]   eng_rd  [NMEM];
  rsrc_e           src_q;
  logic [1:0]      idx_q;

  assign prefix = addr_i[AW-1:OW];
  assign off    = addr_i[OW-1:0];

  bnregif_decode #(.OW(OW)) u_dec (
    .cs_i(cs_i), .we_i(we_i), .prefix_i(prefix), .off_i(off),
    .gen_acc_o(gen_acc), .mem_hit_o(mem_hit), .bad_o(bad)
  );

  bnregif_gen #(.DW(DW), .OW(OW), .LEN_W(LEN_W)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(gen_acc), .we_i(we_i),
    .off_i(off), .wdata_i(wdata_i[LEN_W-1:0]), .done_i(done_i),
    .start_o(start_o), .ready_o(ready_w),
    .mod_len_o(mod_len_o), .msg_len_o(msg_len_o), .exp_len_o(exp_len_o),
    .rdata_o(gen_rdata)
  );

  for (genvar i = 0; i < NMEM; i++) begin : g_mem
    logic          m_we;
    logic [OW-1:0] m_wa;
    logic [DW-1:0] m_wd;
    if (i == RES_IDX) begin : g_eng_wr
      assign m_we = res_we_i;
      assign m_wa = res_waddr_i;
      assign m_wd = res_wdata_i;
    end else begin : g_host_wr
      assign m_we = mem_hit[i] && we_i;
      assign m_wa = off;
      assign m_wd = wdata_i;
    end
    bnregif_mem #(.DW(DW), .OW(OW)) u_mem (
      .clk_i(clk_i), .we_i(m_we), .waddr_i(m_wa), .wdata_i(m_wd),
      .ra_addr_i(off), .ra_data_o(host_rd[i]),
      .rb_addr_i(eng_raddr_i), .rb_data_o(eng_rd[i])
    );
  end

  assign eng_mod_o = eng_rd[0];
  assign eng_exp_o = eng_rd[1];
  assign eng_msg_o = eng_rd[2];
  assign eng_res_o = eng_rd[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_NONE;
      idx_q <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= bad;
      idx_q <= 2'(prefix - 4'd1);
      if (cs_i && !we_i && !bad)
        src_q <= gen_acc ? SRC_GEN : ((|mem_hit) ? SRC_MEM : SRC_NONE);
      else
        src_q <= SRC_NONE;
    end
  end

  always_comb begin
    case (src_q)
      SRC_GEN: rdata_o = gen_rdata;
      SRC_MEM: rdata_o = host_rd[idx_q];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bnregif_chk.sv
`timescale 1ns/1ps
module bnregif_chk #(
  parameter int DW = 32,
  parameter int OW = 8,
  localparam int AW = OW + 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          wdata0_i,
  input logic          done_i,
  input logic          start_i,
  input logic          ready_i,
  input logic [DW-1:0] rdata_i,
  input logic          err_i
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(8'h08);

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i); // R4
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> $past(cs_i && we_i && addr_i == CTRL_ADDR && wdata0_i)); // R4
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !ready_i); // R5
  AST_READY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_i) |-> $past(done_i)); // R5
  AST_BAD_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && addr_i[AW-1:OW] > 4'd4) |=> err_i); // R7
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (rdata_i == '0)); // R7
  AST_RES_WR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i[AW-1:OW] == 4'd4) |=> err_i); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (rdata_i == '0 && !err_i)); // R2
endmodule

bind bignum_regif bnregif_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
  .addr_i(addr_i), .wdata0_i(wdata_i[0]), .done_i(done_i),
  .start_i(start_o), .ready_i(ready_w), .rdata_i(rdata_o), .err_i(err_o)
);

// File: tb/bignum_regif_tb.sv
`timescale 1ns/1ps
module bignum_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, we = 1'b0, done = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, start;
  logic [8:0]  mod_len, msg_len, exp_len;
  logic [7:0]  eng_ra = '0;
  logic [31:0] e_mod, e_exp, e_msg, e_res;
  logic        res_we = 1'b0;
  logic [7:0]  res_wa = '0;
  logic [31:0] res_wd = '0;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  bignum_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .start_o(start),
    .done_i(done), .mod_len_o(mod_len), .msg_len_o(msg_len),
    .exp_len_o(exp_len), .eng_raddr_i(eng_ra), .eng_mod_o(e_mod),
    .eng_exp_o(e_exp), .eng_msg_o(e_msg), .eng_res_o(e_res),
    .res_we_i(res_we), .res_waddr_i(res_wa), .res_wdata_i(res_wd)
  );

  function automatic logic [31:0] pat(int b, int i);
    return 32'(32'h9E37_79B9 * (i + 1)) ^ 32'(b << 24) ^ 32'(i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    cs = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    rd = rdata; er = err;
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(posedge clk); #1; done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    // R2 R6 reset state
    chk("R2 reset rdata", rdata, 0);
    chk("R2 reset err", {31'b0, err}, 0);
    chk("R4 reset start", {31'b0, start}, 0);
    chk("R6 reset lens", {5'b0, mod_len, msg_len, exp_len}, 0);
    // R3 identification
    acc(0, 12'h000, 0, rd, er); chk("R3 id0", rd, 32'h626E_7267);
    acc(0, 12'h001, 0, rd, er); chk("R3 id1", rd, 32'h6D65_7870);
    acc(0, 12'h002, 0, rd, er); chk("R3 ver", rd, 32'h0001_0000);
    // R5 ready after reset
    acc(0, 12'h009, 0, rd, er); chk("R5 ready after reset", rd, 1);
    // R10 ignored writes
    acc(1, 12'h000, 32'hDEAD_BEEF, rd, er); chk("R10 id write err", {31'b0, er}, 0);
    acc(1, 12'h009, 32'h0, rd, er);         chk("R10 stat write err", {31'b0, er}, 0);
    acc(0, 12'h000, 0, rd, er); chk("R10 id0 kept", rd, 32'h626E_7267);
    acc(0, 12'h009, 0, rd, er); chk("R10 stat kept", rd, 1);
    // R6 lengths
    acc(1, 12'h020, 32'h5, rd, er);
    acc(1, 12'h021, 32'h100, rd, er);
    acc(1, 12'h022, 32'hFFFF_FFFF, rd, er);
    chk("R6 mod_len", {23'b0, mod_len}, 32'h5);
    chk("R6 msg_len", {23'b0, msg_len}, 32'h100);
    chk("R6 exp_len", {23'b0, exp_len}, 32'h1FF);
    acc(0, 12'h022, 0, rd, er); chk("R6 exp readback", rd, 32'h1FF);
    acc(0, 12'h021, 0, rd, er); chk("R6 msg readback", rd, 32'h100);
    // R4 R5 start and ready
    acc(1, 12'h008, 32'h1, rd, er);
    chk("R4 start pulse", {31'b0, start}, 1);
    chk("R2 write rdata zero", rd, 0);
    acc(0, 12'h009, 0, rd, er);
    chk("R4 start cleared", {31'b0, start}, 0);
    chk("R5 busy", rd, 0);
    acc(0, 12'h008, 0, rd, er); chk("R4 ctrl reads 0", rd, 0);
    pulse_done();
    acc(0, 12'h009, 0, rd, er); chk("R5 ready after done", rd, 1);
    acc(1, 12'h008, 32'h2, rd, er); chk("R4 no pulse bit0 clear", {31'b0, start}, 0);
    acc(0, 12'h009, 0, rd, er); chk("R5 still ready", rd, 1);
    done = 1'b1;
    acc(1, 12'h008, 32'h1, rd, er);
    done = 1'b0;
    chk("R4 pulse with done", {31'b0, start}, 1);
    acc(0, 12'h009, 0, rd, er); chk("R5 start wins over done", rd, 0);
    pulse_done();
    // R1 host memories sweep
    for (int b = 1; b <= 3; b++)
      for (int i = 0; i < 256; i++) begin
        acc(1, {4'(b), 8'(i)}, pat(b, i), rd, er);
        if (er) chk("R1 write err", {31'b0, er}, 0);
      end
    for (int b = 1; b <= 3; b++)
      for (int i = 0; i < 256; i++) begin
        acc(0, {4'(b), 8'(i)}, 0, rd, er);
        chk($sformatf("R1 bank%0d off%0d", b, i), rd, pat(b, i));
      end
    // R8 engine writes result memory
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); res_we = 1'b1; res_wa = 8'(i); res_wd = pat(4, i);
    end
    @(negedge clk); res_we = 1'b0;
    for (int i = 0; i < 256; i++) begin
      acc(0, {4'd4, 8'(i)}, 0, rd, er);
      chk($sformatf("R8 result off%0d", i), rd, pat(4, i));
    end
    acc(1, 12'h405, 32'h1234_5678, rd, er); chk("R8 host write err", {31'b0, er}, 1);
    acc(0, 12'h405, 0, rd, er); chk("R8 result unchanged", rd, pat(4, 5));
    // R9 engine read ports
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); eng_ra = 8'(i);
      @(posedge clk); #1;
      chk("R9 eng mod", e_mod, pat(1, i));
      chk("R9 eng exp", e_exp, pat(2, i));
      chk("R9 eng msg", e_msg, pat(3, i));
      chk("R9 eng res", e_res, pat(4, i));
    end
    // R7 undefined banks
    for (int b = 5; b < 16; b++) begin
      acc(0, {4'(b), 8'h00}, 0, rd, er);
      chk("R7 bad bank read err", {31'b0, er}, 1);
      chk("R7 bad bank rdata", rd, 0);
      acc(1, {4'(b), 8'h10}, 32'hFFFF_FFFF, rd, er);
      chk("R7 bad bank write err", {31'b0, er}, 1);
    end
    // R7 general offset map
    for (int o = 0; o < 256; o++) begin
      logic ok;
      ok = (o == 0) || (o == 1) || (o == 2) || (o == 8) || (o == 9) ||
           (o == 32) || (o == 33) || (o == 34);
      acc(0, {4'd0, 8'(o)}, 0, rd, er);
      chk($sformatf("R7 gen off%0d err", o), {31'b0, er}, {31'b0, !ok});
      if (!ok) chk("R7 gen bad rdata", rd, 0);
    end
    acc(1, 12'h023, 32'h7, rd, er); chk("R7 undefined write err", {31'b0, er}, 1);
    chk("R7 lens unaffected", {5'b0, mod_len, msg_len, exp_len},
        {5'b0, 9'h5, 9'h100, 9'h1FF});
    acc(0, 12'h101, 0, rd, er); chk("R1 mod untouched by bad writes", rd, pat(1, 1));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule